// File: doc/BRIEF.md
# Memory-Mapped Peripheral Window Controller

This block sits on the data side of a small processor, between the core's load/store bus and the data RAM. Every access carries an address, a write strobe and write data. The block compares the address against a fixed I/O threshold. Accesses below the threshold go to RAM unchanged. Accesses at or above it are steered to a small set of device registers and never reach RAM.

The device registers fall into two kinds. A bank of one-bit LED registers is set or cleared by stores. A capture register samples the external button levels on every rising clock edge, and loads return that captured value. The read data seen by the core is selected from RAM or from the device registers, according to where the address falls.

The block runs on the system clock supplied at its clock input and has no clock source of its own. It uses an asynchronous active-low reset.

Top module: `mmio_ctrl`

## Requirements
- R1: When `bus_addr` is below 0x00007F00, `ram_we` equals `bus_we` and `bus_rdata` equals `ram_rdata` in the same cycle.
- R2: When `bus_addr` is 0x00007F00 or higher, `ram_we` is 0 whatever the value of `bus_we`.
- R3: A store to 0x00007F00 loads bit 0 of `bus_wdata` into `led_out[0]` at the next rising edge. A 1 lights the LED and a 0 turns it off. Every other data bit is ignored.
- R4: A store to 0x00007F04 loads bit 0 of `bus_wdata` into `led_out[1]` and leaves `led_out[0]` unchanged. Each LED register can be written on its own.
- R5: With `bus_we` at 0, no address changes `led_out`.
- R6: `btn_in` is captured on every rising edge. A load from 0x00007F08 returns the captured levels in bits 3:0 and zeros in all higher bits. The value therefore lags `btn_in` by one edge.
- R7: A load from an LED address returns that LED's current state in bit 0 and zeros in all other bits.
- R8: Addresses in the I/O window beyond the button register read as 0, and stores to them change no LED.
- R9: While `rst_n` is low, every LED register and the capture register hold 0. `led_out` is 0, and a load from the button address returns 0.
- R10: A store to the button address does not change `led_out` or the captured button value.
- R11: Inside the I/O window, address bits 1:0 are ignored. For example, 0x00007F05 selects the same register as 0x00007F04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address from the core |
| bus_we | input | 1 | Store strobe from the core |
| bus_wdata | input | 32 | Store data from the core |
| bus_rdata | output | 32 | Load data returned to the core |
| ram_we | output | 1 | Gated write enable sent to RAM |
| ram_rdata | input | 32 | Read data coming back from RAM |
| btn_in | input | 4 | External button levels |
| led_out | output | 2 | LED drive, one bit per LED |

## Verification
The bench targets the threshold edge: 0x7EFC must still write RAM, while 0x7F00 and the top of the address space must not. A wrong comparison would let a store corrupt RAM or would drop a legal RAM store. It also checks that a store to LED1 keeps LED0's value, and that a store with the strobe low changes nothing. An index or enable bug would show up as a disturbed neighbour LED. Button loads are checked against the value driven one edge earlier, not the current one, which catches a missing or doubled capture stage. Stores to the button register, stores to unmapped I/O words and stores with odd low address bits are each followed by loads, so that a decoder that aliases or mis-masks addresses returns a wrong value.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
    typedef enum logic [1:0] {
        RGN_RAM  = 2'd0,
        RGN_LED  = 2'd1,
        RGN_BTN  = 2'd2,
        RGN_NONE = 2'd3
    } region_e;
endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
    import mmio_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] IO_BASE  = 32'h0000_7F00,
    parameter int          NUM_LEDS = 2,
    parameter int          IDX_W    = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  led_idx
);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(IO_BASE);
    localparam int WORD_W = ADDR_W - 2;

    logic [ADDR_W-1:0] offset;
    logic [WORD_W-1:0] word;

    always_comb begin
        offset  = addr - BASE;
        word    = offset[ADDR_W-1:2];
        led_idx = word[IDX_W-1:0];
        if (addr < BASE)
            region = RGN_RAM;
        else if (word < WORD_W'(NUM_LEDS))
            region = RGN_LED;
        else if (word == WORD_W'(NUM_LEDS))
            region = RGN_BTN;
        else
            region = RGN_NONE;
    end
endmodule

// File: rtl/mmio_led_bank.sv
module mmio_led_bank #(
    parameter int NUM_LEDS = 2,
    parameter int IDX_W    = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    idx,
    input  logic                bit_in,
    output logic [NUM_LEDS-1:0] led_q
);
    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                led_q[i] <= 1'b0;
            else if (wr_en && idx == IDX_W'(i))
                led_q[i] <= bit_in;
        end
    end
endmodule

// File: rtl/mmio_btn_capture.sv
module mmio_btn_capture #(
    parameter int NUM_BTNS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_BTNS-1:0] btn_in,
    output logic [NUM_BTNS-1:0] btn_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            btn_q <= '0;
        else
            btn_q <= btn_in;
    end
endmodule

// File: rtl/mmio_ctrl.sv
module mmio_ctrl
    import mmio_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          DATA_W   = 32,
    parameter logic [31:0] IO_BASE  = 32'h0000_7F00,
    parameter int          NUM_LEDS = 2,
    parameter int          NUM_BTNS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                ram_we,
    input  logic [DATA_W-1:0]   ram_rdata,
    input  logic [NUM_BTNS-1:0] btn_in,
    output logic [NUM_LEDS-1:0] led_out
);
    localparam int IDX_W = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1;

    region_e              region;
    logic [IDX_W-1:0]     led_idx;
    logic [NUM_BTNS-1:0]  btn_q;
    logic                 led_wr;

    mmio_decode #(
        .ADDR_W  (ADDR_W),
        .IO_BASE (IO_BASE),
        .NUM_LEDS(NUM_LEDS),
        .IDX_W   (IDX_W)
    ) u_decode (
        .addr   (bus_addr),
        .region (region),
        .led_idx(led_idx)
    );

    assign led_wr = bus_we && (region == RGN_LED);
    assign ram_we = bus_we && (region == RGN_RAM);

    mmio_led_bank #(
        .NUM_LEDS(NUM_LEDS),
        .IDX_W   (IDX_W)
    ) u_leds (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (led_wr),
        .idx   (led_idx),
        .bit_in(bus_wdata[0]),
        .led_q (led_out)
    );

    mmio_btn_capture #(
        .NUM_BTNS(NUM_BTNS)
    ) u_btn (
        .clk   (clk),
        .rst_n (rst_n),
        .btn_in(btn_in),
        .btn_q (btn_q)
    );

    always_comb begin
        unique case (region)
            RGN_RAM:  bus_rdata = ram_rdata;
            RGN_LED:  bus_rdata = DATA_W'(led_out[led_idx]);
            RGN_BTN:  bus_rdata = DATA_W'(btn_q);
            RGN_NONE: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mmio_ctrl_chk.sv
module mmio_ctrl_chk #(
    parameter int          ADDR_W   = 32,
    parameter int          DATA_W   = 32,
    parameter logic [31:0] IO_BASE  = 32'h0000_7F00,
    parameter int          NUM_LEDS = 2,
    parameter int          NUM_BTNS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic                ram_we,
    input logic [DATA_W-1:0]   ram_rdata,
    input logic [NUM_BTNS-1:0] btn_in,
    input logic [NUM_LEDS-1:0] led_out
);
    localparam logic [ADDR_W-1:0] BASE     = ADDR_W'(IO_BASE);
    localparam logic [ADDR_W-1:0] BTN_ADDR = ADDR_W'(IO_BASE + 32'(4 * NUM_LEDS));

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_ram_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr < BASE) |-> (ram_we == bus_we && bus_rdata == ram_rdata));

    assert_ram_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= BASE) |-> !ram_we);

    assert_led0_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == BASE) |=> (led_out[0] == $past(bus_wdata[0])));

    assert_led_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(led_out));

    assert_btn_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && bus_addr == BTN_ADDR) |-> (bus_rdata == DATA_W'($past(btn_in))));

    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |-> (led_out == '0));
endmodule

bind mmio_ctrl mmio_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .IO_BASE (IO_BASE),
    .NUM_LEDS(NUM_LEDS),
    .NUM_BTNS(NUM_BTNS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .ram_we   (ram_we),
    .ram_rdata(ram_rdata),
    .btn_in   (btn_in),
    .led_out  (led_out)
);

// File: tb/tb_mmio_ctrl.sv
`timescale 1ns/1ps
module tb_mmio_ctrl;
    localparam logic [31:0] BASE = 32'h0000_7F00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ram_we;
    logic [31:0] ram_rdata = '0;
    logic [3:0]  btn_in = '0;
    logic [1:0]  led_out;

    always #10 clk = ~clk;

    mmio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ram_we(ram_we),
        .ram_rdata(ram_rdata), .btn_in(btn_in), .led_out(led_out)
    );

    typedef struct {
        logic [31:0] rdata;
        logic        ramwe;
        logic [1:0]  led;
        string       req;
    } exp_t;

    exp_t        sb[$];
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [1:0]  m_led = '0;
    logic [3:0]  m_btn = '0;

    // Monitor: compares each queued expectation mid low phase
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_checks++;
                if (bus_rdata !== e.rdata || ram_we !== e.ramwe || led_out !== e.led) begin
                    n_fail++;
                    $display("FAIL %s: rdata=%h ram_we=%b led=%b expected rdata=%h ram_we=%b led=%b",
                             e.req, bus_rdata, ram_we, led_out, e.rdata, e.ramwe, e.led);
                end
            end
        end
    end

    // Driver: one bus cycle; expectations follow the requirements
    task automatic cyc(input logic rst, input logic [31:0] a, input logic w,
                       input logic [31:0] d, input logic [3:0] b,
                       input logic [31:0] rr, input string req);
        exp_t e;
        logic [31:0] word;
        @(negedge clk);
        rst_n = ~rst; bus_addr = a; bus_we = w; bus_wdata = d; btn_in = b; ram_rdata = rr;
        if (rst) begin m_led = '0; m_btn = '0; end
        word = (a - BASE) >> 2;
        e.req = req;
        e.led = m_led;
        e.ramwe = w && (a < BASE);
        if (a < BASE)        e.rdata = rr;
        else if (word < 2)   e.rdata = {31'b0, m_led[word[0]]};
        else if (word == 2)  e.rdata = {28'b0, m_btn};
        else                 e.rdata = '0;
        sb.push_back(e);
        @(posedge clk);
        #1;
        if (!rst) begin
            if (w && a >= BASE && word < 2) m_led[word[0]] = d[0];
            m_btn = b;
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        cyc(1, BASE + 8, 0, 0, 4'hF, 0, "R9 btn reads 0 in reset");
        cyc(1, BASE, 1, 1, 4'hF, 0, "R9 led held in reset");
        // R1: RAM passthrough
        cyc(0, 32'h2000, 1, 32'h1234, 4'h0, 32'hDEAD_BEEF, "R1 ram store");
        cyc(0, 32'h2000, 0, 0, 4'h0, 32'hCAFE_F00D, "R1 ram load");
        cyc(0, 32'h7EFC, 1, 1, 4'h0, 32'h5555_AAAA, "R1 boundary below window");
        // R2/R3
        cyc(0, BASE, 1, 1, 4'h0, 32'h1111_1111, "R2 R3 led0 on, ram blocked");
        cyc(0, BASE, 0, 0, 4'h0, 32'h2222_2222, "R3 R7 led0 reads 1");
        cyc(0, 32'hFFFF_FFFC, 1, 1, 4'h0, 32'h3333_3333, "R2 top address blocked");
        cyc(0, BASE, 1, 0, 4'h0, 0, "R3 led0 off");
        cyc(0, BASE, 0, 0, 4'h0, 0, "R3 R7 led0 reads 0");
        cyc(0, BASE, 1, 32'hFFFF_FFFF, 4'h0, 0, "R3 led0 on again");
        // R4
        cyc(0, BASE + 4, 1, 1, 4'h0, 0, "R4 led1 on, led0 kept");
        cyc(0, BASE + 4, 0, 0, 4'h0, 0, "R4 R7 led1 reads 1");
        cyc(0, BASE, 1, 32'hFFFF_FFFE, 4'h0, 0, "R3 only bit0 used");
        cyc(0, BASE, 0, 0, 4'h0, 0, "R4 led1 unchanged by led0 store");
        // R5
        cyc(0, BASE + 4, 0, 0, 4'h0, 0, "R5 no strobe to led1");
        cyc(0, BASE, 0, 1, 4'h0, 0, "R5 led0 unchanged");
        // R6
        cyc(0, BASE + 8, 0, 0, 4'hA, 0, "R6 previous capture");
        cyc(0, BASE + 8, 0, 0, 4'h5, 0, "R6 sees A");
        cyc(0, BASE + 8, 0, 0, 4'h5, 0, "R6 sees 5");
        // R10
        cyc(0, BASE + 8, 1, 32'hFFFF_FFFF, 4'h3, 0, "R10 store to btn");
        cyc(0, BASE + 8, 0, 0, 4'h3, 0, "R10 btn shows capture, leds same");
        // R8
        cyc(0, BASE + 12, 1, 1, 4'h0, 32'h7777_7777, "R8 unmapped store");
        cyc(0, BASE + 12, 0, 0, 4'h0, 32'h7777_7777, "R8 unmapped reads 0");
        cyc(0, BASE + 32'h80, 0, 0, 4'h0, 0, "R8 far unmapped reads 0");
        // R11
        cyc(0, BASE + 5, 1, 0, 4'h0, 0, "R11 0x7F05 clears led1");
        cyc(0, BASE + 7, 0, 0, 4'h0, 0, "R11 0x7F07 reads led1");
        cyc(0, BASE + 1, 1, 1, 4'h0, 0, "R11 0x7F01 sets led0");
        cyc(0, BASE + 4, 1, 1, 4'h9, 0, "R4 led1 on");
        cyc(0, BASE + 8, 0, 0, 4'h9, 0, "R6 both leds on, btn 9");
        // R9 mid-run reset
        cyc(1, BASE + 8, 0, 0, 4'h9, 0, "R9 async clear");
        cyc(0, BASE, 0, 0, 4'h6, 0, "R9 led0 cleared after reset");
        cyc(0, BASE + 8, 0, 0, 4'h0, 0, "R6 capture after reset");
        @(negedge clk);
        #8;
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule